// File: doc/BRIEF.md
# Saturating Multiply-Accumulate with Guard Bits

This block multiplies two signed N-bit operands each clock cycle it is asked to, and adds the full 2N-bit product to a running sum or takes it away. The running sum is 2N+G bits wide. The G guard bits above the product width let a chain of products move well outside the N-bit range and come back without losing information. The N-bit result port is taken from the running sum through a clamp. Any sum above the largest N-bit code is shown as that largest code, and any sum below the smallest N-bit code is shown as that smallest code. A sticky flag records that a clamp has occurred.

A typical use is a short dot product or filter tap loop. The caller pulses a clear, presents operand pairs with a strobe, and selects add or subtract for each pair. It then reads a result that never shows the wrap-around of plain modular arithmetic. The running sum also stops at its own limits instead of wrapping. A very long run of same-sign products therefore stays pinned at the wide extreme.

Top module: `sat_mac_acc`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `acc_y` is 0 and `sat_flag` is 0.
- R2: With `vld`=1, `clr`=0 and `sub`=0, the running sum grows by the signed product `op_a`*`op_b`. The operands are two's-complement N-bit values. When the new sum lies within -2^(N-1) to 2^(N-1)-1, `acc_y` shows it exactly, from the cycle after the clock edge.
- R3: With `vld`=1, `clr`=0 and `sub`=1, the running sum is reduced by `op_a`*`op_b`.
- R4: With `vld`=0 and `clr`=0, the running sum does not change, whatever `sub`, `op_a` and `op_b` hold.
- R5: `clr`=1 sets the running sum and the sticky flag to 0 at the next edge. It overrides `vld`.
- R6: A sum above 2^(N-1)-1 is shown on `acc_y` as 0 followed by N-1 ones (0111 for N=4). For example, 5*2 gives 0111.
- R7: A sum below -2^(N-1) is shown as 1 followed by N-1 zeros (1000 for N=4).
- R8: Intermediate sums outside the N-bit range are kept exactly. For N=4, adding 5*2 and then subtracting 1*4 shows 6.
- R9: `sat_flag` goes to 1 in the first cycle in which `acc_y` shows a clamped value. It stays 1 until a clear, even after the sum returns into range.
- R10: The running sum saturates at -2^(2N+G-1) and 2^(2N+G-1)-1 instead of wrapping.
- R11: Subtracting (-2^(N-1))*1 from a zero sum shows the largest positive code and sets `sat_flag`. For N=4, -(-8) shows 0111.
- R12: The product is the exact signed 2N-bit product for every operand pair, including (-2^(N-1))*(-2^(N-1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Zero the running sum and the sticky flag; highest priority |
| vld | input | 1 | Apply the operand pair this cycle |
| sub | input | 1 | 1: subtract the product, 0: add it |
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement |
| acc_y | output | N | Clamped view of the running sum |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
Every result appears one edge after the command that causes it. The sum register updates on the edge, and both the clamp on `acc_y` and the rise of `sat_flag` follow from it without a further register. The bench drives each command just after a falling edge and compares both outputs at the next falling edge, so each comparison sees exactly one applied command. A reference running sum, clamped with ordinary integer arithmetic in the bench, supplies the expected values. This covers a full sweep of every operand pair in add, subtract and clear-with-valid form, and sequences for guard-bit recovery, wide saturation and stickiness.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  // Command applied to the running sum in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_ADD   = 2'd2,
    ACT_SUB   = 2'd3
  } act_e;

  // Clear outranks the strobe; the strobe outranks holding.
  function automatic act_e decode_act(input logic clr, input logic vld, input logic sub);
    if (clr)      return ACT_CLEAR;
    else if (!vld) return ACT_HOLD;
    else if (sub) return ACT_SUB;
    else          return ACT_ADD;
  endfunction

endpackage

// File: rtl/sacc_mul.sv
// Signed shift-add multiplier. Rows below the top one are the sign-extended
// multiplicand shifted by the bit position; the top multiplier bit has a
// negative weight, so its row is the negated shifted multiplicand.
module sacc_mul #(
  parameter int N = 4
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] prod
);
  localparam int PW = 2 * N;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] rows [N];

  function automatic logic [PW-1:0] neg_w(input logic [PW-1:0] v);
    return ~v + PW'(1);
  endfunction

  assign a_ext = {{N{a[N-1]}}, a};

  generate
    for (genvar i = 0; i < N; i++) begin : g_row
      if (i == N - 1) begin : g_top
        assign rows[i] = b[i] ? neg_w(a_ext << i) : '0;
      end else begin : g_low
        assign rows[i] = b[i] ? (a_ext << i) : '0;
      end
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int i = 0; i < N; i++) begin
      prod = prod + rows[i];
    end
  end
endmodule

// File: rtl/sacc_accum.sv
// Wide running sum. One extra bit above the register width exposes overflow:
// when the top two bits of the extended sum differ, it left the register range.
module sacc_accum
  import sacc_pkg::*;
#(
  parameter int N = 4,
  parameter int G = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  act_e                act,
  input  logic [2*N-1:0]      prod,
  output logic [2*N+G-1:0]    acc_q,
  output logic                acc_clip
);
  localparam int AW = 2 * N + G;
  localparam int SW = AW + 1;
  localparam logic [AW-1:0] WIDE_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] WIDE_MIN = {1'b1, {(AW-1){1'b0}}};

  logic [SW-1:0] acc_w, prod_w, sum_w;
  logic          ovf;
  logic [AW-1:0] acc_d;

  function automatic logic [SW-1:0] widen(input logic [2*N-1:0] p);
    return {{(SW-2*N){p[2*N-1]}}, p};
  endfunction

  assign acc_w  = {acc_q[AW-1], acc_q};
  assign prod_w = widen(prod);
  assign sum_w  = (act == ACT_SUB) ? (acc_w - prod_w) : (acc_w + prod_w);
  assign ovf    = sum_w[SW-1] ^ sum_w[SW-2];

  always_comb begin
    unique case (act)
      ACT_CLEAR:        acc_d = '0;
      ACT_ADD, ACT_SUB: acc_d = ovf ? (sum_w[SW-1] ? WIDE_MIN : WIDE_MAX) : sum_w[AW-1:0];
      default:          acc_d = acc_q;
    endcase
  end

  assign acc_clip = ((act == ACT_ADD) || (act == ACT_SUB)) && ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/sacc_outsat.sv
// Narrow view of the wide sum: the value fits when every bit from the narrow
// sign bit upward agrees; otherwise the sign picks the extreme code.
module sacc_outsat #(
  parameter int N  = 4,
  parameter int AW = 10
) (
  input  logic [AW-1:0] v,
  output logic [N-1:0]  y,
  output logic          clip
);
  localparam logic [N-1:0] NAR_MAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] NAR_MIN = {1'b1, {(N-1){1'b0}}};

  logic [AW-N:0] upper;

  assign upper = v[AW-1:N-1];
  assign clip  = !((&upper) || !(|upper));
  assign y     = clip ? (v[AW-1] ? NAR_MIN : NAR_MAX) : v[N-1:0];
endmodule

// File: rtl/sat_mac_acc.sv
module sat_mac_acc
  import sacc_pkg::*;
#(
  parameter int N = 4,
  parameter int G = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         vld,
  input  logic         sub,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N-1:0] acc_y,
  output logic         sat_flag
);
  localparam int AW = 2 * N + G;

  act_e             act;
  logic [2*N-1:0]   prod;
  logic [AW-1:0]    acc_q;
  logic             acc_clip;
  logic             out_clip;
  logic             sat_q;

  assign act = decode_act(clr, vld, sub);

  sacc_mul #(.N(N)) i_mul (
    .a    (op_a),
    .b    (op_b),
    .prod (prod)
  );

  sacc_accum #(.N(N), .G(G)) i_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .prod     (prod),
    .acc_q    (acc_q),
    .acc_clip (acc_clip)
  );

  sacc_outsat #(.N(N), .AW(AW)) i_outsat (
    .v    (acc_q),
    .y    (acc_y),
    .clip (out_clip)
  );

  // Memory of clamps already shown; the live clamp is merged in so the flag
  // rises in the same cycle as the clamped value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sat_q <= 1'b0;
    else if (act == ACT_CLEAR) sat_q <= 1'b0;
    else if (out_clip)       sat_q <= 1'b1;
  end

  assign sat_flag = sat_q | out_clip;
endmodule

// File: rtl/sacc_chk.sv
module sacc_chk #(
  parameter int N  = 4,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          vld,
  input logic [N-1:0]  acc_y,
  input logic          sat_flag,
  input logic [AW-1:0] acc_q,
  input logic          acc_clip,
  input logic          out_clip
);
  localparam logic [AW-1:0] HI = AW'((1 << (N - 1)) - 1);
  localparam logic [AW-1:0] LO = ~HI;
  localparam logic [AW-1:0] WMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] WMIN = {1'b1, {(AW-1){1'b0}}};

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_y == '0 && !sat_flag)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !vld) |=> $stable(acc_q)); // R4
  AST_POS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(acc_q) > $signed(HI)) |-> (acc_y == {1'b0, {(N-1){1'b1}}})); // R6
  AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(acc_q) < $signed(LO)) |-> (acc_y == {1'b1, {(N-1){1'b0}}})); // R7
  AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (($signed(acc_q) <= $signed(HI)) && ($signed(acc_q) >= $signed(LO))) |-> (acc_y == acc_q[N-1:0])); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !clr) |=> sat_flag); // R9
  AST_SAT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> out_clip); // R9
  AST_WIDE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clip |=> (acc_q == WMAX || acc_q == WMIN)); // R10
endmodule

bind sat_mac_acc sacc_chk #(.N(N), .AW(AW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .vld      (vld),
  .acc_y    (acc_y),
  .sat_flag (sat_flag),
  .acc_q    (acc_q),
  .acc_clip (acc_clip),
  .out_clip (out_clip)
);

// File: tb/test_sat_mac_acc.sv
`timescale 1ns/1ps
module test_sat_mac_acc;
  localparam int N = 4;
  localparam int G = 2;
  localparam int AW = 2 * N + G;
  localparam int NMAX = (1 << (N - 1)) - 1;
  localparam int NMIN = -(1 << (N - 1));
  localparam int WMAX = (1 << (AW - 1)) - 1;
  localparam int WMIN = -(1 << (AW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0, sub = 1'b0;
  logic [N-1:0] op_a = '0, op_b = '0;
  logic [N-1:0] acc_y;
  logic sat_flag;

  int total = 0;
  int bad = 0;
  int m_acc = 0;
  bit m_sat = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sat_mac_acc #(.N(N), .G(G)) i_sat_mac_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld), .sub(sub),
    .op_a(op_a), .op_b(op_b), .acc_y(acc_y), .sat_flag(sat_flag)
  );

  function automatic int narrow(input int v);
    if (v > NMAX) return NMAX;
    if (v < NMIN) return NMIN;
    return v;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive one command after a falling edge, compare at the next falling edge.
  task automatic step(input string req, input bit c, input bit v, input bit s,
                      input int a, input int b);
    int t;
    clr = c; vld = v; sub = s; op_a = N'(a); op_b = N'(b);
    @(negedge clk);
    if (c) begin
      m_acc = 0; m_sat = 1'b0;
    end else if (v) begin
      t = s ? m_acc - a * b : m_acc + a * b;
      if (t > WMAX) t = WMAX;
      if (t < WMIN) t = WMIN;
      m_acc = t;
    end
    if (narrow(m_acc) != m_acc) m_sat = 1'b1;
    check(req, int'($signed(acc_y)), narrow(m_acc));
    check(req, int'(sat_flag), int'(m_sat));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'($signed(acc_y)), 0);
    check("R1", int'(sat_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'($signed(acc_y)), 0);
    check("R1", int'(sat_flag), 0);

    // Sweep every operand pair: add, subtract back, clear with strobe, negate.
    for (int a = NMIN; a <= NMAX; a++) begin
      for (int b = NMIN; b <= NMAX; b++) begin
        step("R5", 1, 0, 0, 0, 0);
        step("R2 R12", 0, 1, 0, a, b);
        step("R3", 0, 1, 1, a, b);
        step("R5 clear over vld", 1, 1, 0, a, b);
        step("R3 negate", 0, 1, 1, a, b);
        step("R4", 0, 0, 1, b, a);
      end
    end

    // Hold ignores sub and operands.
    step("R5", 1, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 3, 2);
    step("R4", 0, 0, 1, 7, 7);
    step("R4", 0, 0, 0, -8, -8);

    // Guard bits absorb the intermediate 10.
    step("R5", 1, 0, 0, 0, 0);
    step("R6", 0, 1, 0, 5, 2);
    step("R8", 0, 1, 1, 1, 4);
    check("R8", int'($signed(acc_y)), 6);
    check("R9", int'(sat_flag), 1);
    step("R5", 1, 0, 0, 0, 0);

    // Negative clamp.
    step("R7", 0, 1, 0, -8, 7);
    check("R7", int'(acc_y), 8);
    step("R5", 1, 0, 0, 0, 0);

    // Negating the most negative code.
    step("R11", 0, 1, 1, -8, 1);
    check("R11", int'(acc_y), 7);
    step("R5", 1, 0, 0, 0, 0);

    // Wide saturation: nine +64 steps pin at the top, eight -64 steps land at -1.
    for (int i = 0; i < 9; i++) step("R10", 0, 1, 0, -8, -8);
    for (int i = 0; i < 8; i++) step("R10", 0, 1, 1, -8, -8);
    check("R10", int'($signed(acc_y)), -1);
    check("R9", int'(sat_flag), 1);
    step("R5", 1, 0, 0, 0, 0);
    check("R9", int'(sat_flag), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule